// File: doc/BRIEF.md
# Monochrome Bit-Mapped Framebuffer with Raster Read-Out

This block holds the image for a black-and-white display of 256 rows by 512 columns. Each pixel is one bit, so the image fits in 8192 words of 16 bits. A processor reaches the store one word at a time. It gives a 13-bit word address, and a load strobe writes the data word on the clock edge. The word at the address comes back on a read path with no clock delay. A set bit is a black pixel and a clear bit is a white pixel.

Next to the word port there are two read paths. The first is a combinational lookup of one pixel: it takes a row and a column and returns that pixel's bit. The second is a raster scan. It walks every pixel in display order and sends each one out with its row and column on a valid/ready stream. A consumer stalls the stream by holding ready low. While valid is high and ready is low, the bit, row and column stay frozen and the scan does not move on. Transfer happens on any clock edge where valid and ready are both high. The scan only starts new pixels while the enable input is high. Display sync and blanking timing are not part of this block.

Top module: `fb_screen`

## Requirements
- R1: The pixel at row r, column c is bit (c mod 16) of the word at address r*32 + c/16 (integer division). pix_bit returns that bit in the same cycle the row and column are applied.
- R2: When cpu_load is high at a rising edge, cpu_wdata is stored at cpu_addr. cpu_rdata shows the word at cpu_addr combinationally, so a read after the write returns the written word.
- R3: When cpu_load is low, a clock edge changes no stored word, whatever cpu_wdata holds.
- R4: Scan pixels come out column by column along a row, then row by row. After row 255, column 511, the next pixel is row 0, column 0.
- R5: A scan pixel is issued on an edge where scan_en is high and the output slot is free (scan_valid low or scan_ready high). That pixel appears on scan_bit, scan_row and scan_col with scan_valid high right after that same edge. This is one cycle after its position was held in the raster counter.
- R6: While scan_valid is high and scan_ready is low, scan_valid, scan_bit, scan_row and scan_col stay unchanged.
- R7: While scan_en is low, no new pixel is issued. scan_valid falls after the held pixel is accepted. The raster position is kept, so the next pixel after scan_en returns high is the one that followed the last issued pixel.
- R8: If a processor write hits the word that the scan reads on the same edge, the scan pixel carries the value from before the write.
- R9: After reset, scan_valid is low and the first scanned pixel is row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the scan state |
| cpu_addr | input | 13 | Word address for processor access |
| cpu_wdata | input | 16 | Word to store |
| cpu_load | input | 1 | Write strobe |
| cpu_rdata | output | 16 | Word at cpu_addr, combinational |
| pix_row | input | 8 | Row of the single-pixel lookup |
| pix_col | input | 9 | Column of the single-pixel lookup |
| pix_bit | output | 1 | Pixel value at pix_row, pix_col (1 = black) |
| scan_en | input | 1 | Allows the raster scan to issue pixels |
| scan_ready | input | 1 | Consumer accepts the scan pixel |
| scan_valid | output | 1 | Scan pixel outputs hold a pixel |
| scan_bit | output | 1 | Scanned pixel value |
| scan_row | output | 8 | Row of the scanned pixel |
| scan_col | output | 9 | Column of the scanned pixel |

## Verification
The whole store is filled with random words. The pixel lookup is then tried at random positions and at the word edges (columns 15, 16, 511 and row 255), which shows whether the bit order and the word order are right. One complete frame plus a few extra pixels is scanned while ready drops at random and processor writes land at random places. Some of those writes are aimed at the word the scan is about to read. This shows apart the raster order, the wrap back to the origin, holding under a stall, and old-value reads on a collision. Directed steps cover a write with load low and a pause of the scan enable.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int FB_ROWS_DEF = 256;
  localparam int FB_COLS_DEF = 512;
  localparam int FB_WORD_DEF = 16;

  // linear word index of a pixel for a given row pitch in words
  function automatic int word_index(input int row, input int col,
                                    input int words_per_row, input int word_bits);
    return row * words_per_row + col / word_bits;
  endfunction
endpackage

// File: rtl/fb_store.sv
module fb_store #(
  parameter int DEPTH = 8192,
  parameter int WORD  = 16,
  parameter int AW    = 13
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [WORD-1:0] wr_data,
  input  logic [AW-1:0]   rda_addr,
  output logic [WORD-1:0] rda_data,
  input  logic [AW-1:0]   rdb_addr,
  output logic [WORD-1:0] rdb_data,
  input  logic            rdc_en,
  input  logic [AW-1:0]   rdc_addr,
  output logic [WORD-1:0] rdc_data
);
  logic [WORD-1:0] mem [DEPTH];
  logic [WORD-1:0] rdc_q;

  // write and the registered scan read share one edge; the read sees the old word
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rdc_en) rdc_q <= mem[rdc_addr];
  end

  assign rda_data = mem[rda_addr];
  assign rdb_data = mem[rdb_addr];
  assign rdc_data = rdc_q;
endmodule

// File: rtl/fb_raster.sv
module fb_raster #(
  parameter int ROWS = 256,
  parameter int COLS = 512,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic col_end, row_end;
  assign col_end = (col == COL_LAST);
  assign row_end = (row == ROW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      if (col_end) begin
        col <= '0;
        row <= row_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_scan_stage.sv
module fb_scan_stage #(
  parameter int WORD = 16,
  parameter int RW   = 8,
  parameter int CW   = 9,
  localparam int BW  = $clog2(WORD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            out_ready,
  input  logic [RW-1:0]   cnt_row,
  input  logic [CW-1:0]   cnt_col,
  input  logic [WORD-1:0] word_q,
  output logic            issue,
  output logic            out_valid,
  output logic            out_bit,
  output logic [RW-1:0]   out_row,
  output logic [CW-1:0]   out_col
);
  logic [BW-1:0] sel_q;

  assign issue = scan_en && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      sel_q     <= '0;
    end else if (issue) begin
      out_valid <= 1'b1;
      out_row   <= cnt_row;
      out_col   <= cnt_col;
      sel_q     <= cnt_col[BW-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // word_q is captured by the store on the same issuing edge
  assign out_bit = word_q[sel_q];
endmodule

// File: rtl/fb_screen.sv
module fb_screen #(
  parameter int ROWS = fb_pkg::FB_ROWS_DEF,
  parameter int COLS = fb_pkg::FB_COLS_DEF,
  parameter int WORD = fb_pkg::FB_WORD_DEF,
  localparam int WPR   = COLS / WORD,
  localparam int DEPTH = ROWS * WPR,
  localparam int AW    = $clog2(DEPTH),
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int BW    = $clog2(WORD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [WORD-1:0] cpu_wdata,
  input  logic            cpu_load,
  output logic [WORD-1:0] cpu_rdata,
  input  logic [RW-1:0]   pix_row,
  input  logic [CW-1:0]   pix_col,
  output logic            pix_bit,
  input  logic            scan_en,
  input  logic            scan_ready,
  output logic            scan_valid,
  output logic            scan_bit,
  output logic [RW-1:0]   scan_row,
  output logic [CW-1:0]   scan_col
);
  logic [RW-1:0]   cnt_row;
  logic [CW-1:0]   cnt_col;
  logic            issue;
  logic [AW-1:0]   pix_addr, scan_addr;
  logic [WORD-1:0] pix_word, scan_word;

  assign pix_addr  = AW'(fb_pkg::word_index(int'(pix_row), int'(pix_col), WPR, WORD));
  assign scan_addr = AW'(fb_pkg::word_index(int'(cnt_row), int'(cnt_col), WPR, WORD));
  assign pix_bit   = pix_word[pix_col[BW-1:0]];

  fb_store #(.DEPTH(DEPTH), .WORD(WORD), .AW(AW)) u_store (
    .clk      (clk),
    .wr_en    (cpu_load),
    .wr_addr  (cpu_addr),
    .wr_data  (cpu_wdata),
    .rda_addr (cpu_addr),
    .rda_data (cpu_rdata),
    .rdb_addr (pix_addr),
    .rdb_data (pix_word),
    .rdc_en   (issue),
    .rdc_addr (scan_addr),
    .rdc_data (scan_word)
  );

  fb_raster #(.ROWS(ROWS), .COLS(COLS)) u_raster (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (issue),
    .row   (cnt_row),
    .col   (cnt_col)
  );

  fb_scan_stage #(.WORD(WORD), .RW(RW), .CW(CW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .out_ready (scan_ready),
    .cnt_row   (cnt_row),
    .cnt_col   (cnt_col),
    .word_q    (scan_word),
    .issue     (issue),
    .out_valid (scan_valid),
    .out_bit   (scan_bit),
    .out_row   (scan_row),
    .out_col   (scan_col)
  );
endmodule

// File: rtl/fb_screen_chk.sv
module fb_screen_chk #(
  parameter int ROWS = 256,
  parameter int COLS = 512,
  parameter int WORD = 16,
  localparam int DEPTH = ROWS * (COLS / WORD),
  localparam int AW = $clog2(DEPTH),
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   cpu_addr,
  input logic [WORD-1:0] cpu_wdata,
  input logic            cpu_load,
  input logic [WORD-1:0] cpu_rdata,
  input logic            scan_en,
  input logic            scan_ready,
  input logic            scan_valid,
  input logic            scan_bit,
  input logic [RW-1:0]   scan_row,
  input logic [CW-1:0]   scan_col
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_load |=> ((cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_wdata)))); // R2

  AST_NO_LOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_load |=> (!$stable(cpu_addr) || $stable(cpu_rdata))); // R3

  AST_COL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_ready && scan_en) |=>
      (scan_valid && (scan_col == (($past(scan_col) == COL_LAST) ? '0 : $past(scan_col) + 1'b1)))); // R4

  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_ready && scan_en && scan_col == COL_LAST) |=>
      (scan_row == (($past(scan_row) == ROW_LAST) ? '0 : $past(scan_row) + 1'b1))); // R4

  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_valid && scan_en) |=> scan_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && !scan_ready) |=>
      (scan_valid && $stable(scan_bit) && $stable(scan_row) && $stable(scan_col))); // R6

  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_ready && !scan_en) |=> !scan_valid); // R7

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_valid && !scan_en) |=> !scan_valid); // R7
endmodule

bind fb_screen fb_screen_chk #(.ROWS(ROWS), .COLS(COLS), .WORD(WORD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_load   (cpu_load),
  .cpu_rdata  (cpu_rdata),
  .scan_en    (scan_en),
  .scan_ready (scan_ready),
  .scan_valid (scan_valid),
  .scan_bit   (scan_bit),
  .scan_row   (scan_row),
  .scan_col   (scan_col)
);

// File: tb/fb_screen_test.sv
`timescale 1ns/1ps
module fb_screen_test;
  localparam int NW = 8192;
  localparam int FRAME = 256 * 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_load = 1'b0;
  logic [15:0] cpu_rdata;
  logic [7:0]  pix_row = '0;
  logic [8:0]  pix_col = '0;
  logic        pix_bit;
  logic        scan_en = 1'b0;
  logic        scan_ready = 1'b0;
  logic        scan_valid, scan_bit;
  logic [7:0]  scan_row;
  logic [8:0]  scan_col;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NW];

  always #2 clk = ~clk;

  fb_screen uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_load(cpu_load), .cpu_rdata(cpu_rdata), .pix_row(pix_row), .pix_col(pix_col),
    .pix_bit(pix_bit), .scan_en(scan_en), .scan_ready(scan_ready), .scan_valid(scan_valid),
    .scan_bit(scan_bit), .scan_row(scan_row), .scan_col(scan_col)
  );

  function automatic int waddr(input int r, input int c);
    return r * 32 + c / 16;
  endfunction

  function automatic logic mpix(input int r, input int c);
    logic [15:0] w;
    w = model[waddr(r, c)];
    return w[c % 16];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_pix(input int r, input int c);
    pix_row = 8'(r);
    pix_col = 9'(c);
    #1;
    check(pix_bit == mpix(r, c), "R1 pixel lookup", int'(pix_bit), int'(mpix(r, c)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_r, exp_c, arrivals;
    bit issued_prev, stalled_prev, collide_prev, seen_last, pw_v;
    int pw_a;
    logic [15:0] pw_d;
    logic sv_bit;
    logic [7:0] sv_row;
    logic [8:0] sv_col;

    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(scan_valid == 1'b0, "R9 valid low in reset", int'(scan_valid), 0);
    rst_n = 1'b1;

    // fill the store
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      cpu_addr = 13'(i);
      cpu_wdata = 16'($urandom);
      cpu_load = 1'b1;
      model[i] = cpu_wdata;
    end
    @(negedge clk);
    cpu_load = 1'b0;
    check(scan_valid == 1'b0, "R9 valid low after reset", int'(scan_valid), 0);

    // R2 directed write then readback
    cpu_addr = 13'd100; cpu_wdata = 16'hA5C3; cpu_load = 1'b1; model[100] = 16'hA5C3;
    @(negedge clk);
    cpu_load = 1'b0;
    #1 check(cpu_rdata == 16'hA5C3, "R2 write readback", int'(cpu_rdata), 32'hA5C3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cpu_addr = 13'($urandom % NW);
      #1 check(cpu_rdata == model[cpu_addr], "R2 random readback", int'(cpu_rdata), int'(model[cpu_addr]));
    end

    // R3 load low ignored
    @(negedge clk);
    cpu_addr = 13'd5; cpu_wdata = ~model[5]; cpu_load = 1'b0;
    @(negedge clk);
    #1 check(cpu_rdata == model[5], "R3 no write without load", int'(cpu_rdata), int'(model[5]));

    // R1 pixel lookups
    check_pix(0, 0); check_pix(0, 15); check_pix(0, 16); check_pix(1, 0);
    check_pix(255, 511); check_pix(255, 496); check_pix(128, 255);
    for (int i = 0; i < 60; i++) check_pix(int'($urandom % 256), int'($urandom % 512));

    // scan with random back-pressure and colliding writes
    exp_r = 0; exp_c = 0; arrivals = 0;
    issued_prev = 0; stalled_prev = 0; collide_prev = 0; seen_last = 0; pw_v = 0;
    pw_a = 0; pw_d = '0; sv_bit = 0; sv_row = '0; sv_col = '0;
    forever begin
      @(negedge clk);
      if (issued_prev) begin
        logic eb;
        eb = mpix(exp_r, exp_c);
        if (arrivals == 0)
          check(scan_valid && scan_row == 0 && scan_col == 0, "R9 first pixel origin",
                int'({scan_row, scan_col}), 0);
        if (exp_r == 0 && exp_c == 0 && seen_last)
          check(scan_row == 0 && scan_col == 0, "R4 wrap to origin",
                int'({scan_row, scan_col}), 0);
        check(scan_valid && scan_row == 8'(exp_r) && scan_col == 9'(exp_c), "R4 R5 scan position",
              int'({scan_valid, scan_row, scan_col}), int'({1'b1, 8'(exp_r), 9'(exp_c)}));
        if (collide_prev)
          check(scan_bit == eb, "R8 old value on collision", int'(scan_bit), int'(eb));
        else
          check(scan_bit == eb, "R5 scan pixel value", int'(scan_bit), int'(eb));
        if (exp_r == 255 && exp_c == 511) seen_last = 1;
        arrivals++;
        exp_c++;
        if (exp_c == 512) begin exp_c = 0; exp_r = (exp_r + 1) % 256; end
      end else if (stalled_prev) begin
        check(scan_valid && scan_bit == sv_bit && scan_row == sv_row && scan_col == sv_col,
              "R6 hold under stall", int'({scan_valid, scan_bit, scan_row, scan_col}),
              int'({1'b1, sv_bit, sv_row, sv_col}));
      end
      if (pw_v) model[pw_a] = pw_d;
      if (arrivals >= FRAME + 40) begin
        scan_en = 1'b0; scan_ready = 1'b1; cpu_load = 1'b0;
        break;
      end
      scan_en = 1'b1;
      scan_ready = ($urandom % 16) != 0;
      pw_v = ($urandom % 4) == 0;
      pw_a = (($urandom % 2) == 0) ? waddr(exp_r, exp_c) : int'($urandom % NW);
      pw_d = 16'($urandom);
      cpu_load = pw_v; cpu_addr = 13'(pw_a); cpu_wdata = pw_d;
      issued_prev = scan_en && (!scan_valid || scan_ready);
      collide_prev = issued_prev && pw_v && pw_a == waddr(exp_r, exp_c);
      stalled_prev = scan_valid && !scan_ready;
      sv_bit = scan_bit; sv_row = scan_row; sv_col = scan_col;
    end

    // R7 pause and resume
    @(negedge clk);
    check(scan_valid == 1'b0, "R7 valid drops when paused", int'(scan_valid), 0);
    repeat (10) @(negedge clk);
    check(scan_valid == 1'b0, "R7 stays idle when paused", int'(scan_valid), 0);
    scan_en = 1'b1;
    @(negedge clk);
    scan_en = 1'b0;
    check(scan_valid && scan_row == 8'(exp_r) && scan_col == 9'(exp_c), "R7 resume position",
          int'({scan_valid, scan_row, scan_col}), int'({1'b1, 8'(exp_r), 9'(exp_c)}));
    check(scan_bit == mpix(exp_r, exp_c), "R7 resume pixel", int'(scan_bit), int'(mpix(exp_r, exp_c)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule